// File: doc/BRIEF.md
# Sixteen-Line Interrupt Expander

This block collects up to sixteen peripheral interrupt lines onto one host interrupt request. Each raw line first passes through a two-flop synchronizer. A synchronized high level then sets a sticky pending bit. Software clears a pending bit by writing a one to its position. Each line also has an enable bit, and the host request is asserted while any pending bit has its enable bit set. On a typical board, two external serial channels drive lines 10 and 11, and the other lines serve other companion devices.

Software never writes the enable mask directly. One register address sets bits, another clears them, and both addresses read back the current mask. A separate read-only address returns the synchronized line levels without latching them. This lets software see whether a level source is still active. The bus is a plain synchronous register port. Reads are combinational from the address, and writes take effect at the rising clock edge where the write enable is high.

Top module: `irq_expander`

## Requirements
- R1: After reset, the enable mask and the pending status are all zeros, every readable address returns 0x0000, and irq_o is low.
- R2: Writing to offset 0x1A sets each enable bit whose write-data bit is 1 and leaves the others unchanged. Reading 0x1A returns the enable mask.
- R3: Writing to offset 0x1C clears each enable bit whose write-data bit is 1 and leaves the others unchanged. Reading 0x1C also returns the enable mask.
- R4: Reading offset 0x16 returns the pending status, where bit n belongs to line n. Line n going high sets bit n at the third rising edge after the change. The bit stays set after the line falls.
- R5: Writing to offset 0x16 clears each pending bit whose write-data bit is 1. Zero bits leave their pending bits unchanged.
- R6: When a clear is written to a pending bit whose synchronized line is still high, the set wins and the bit stays set.
- R7: Reading offset 0x18 returns the synchronized line levels. A change on a line shows there after two rising edges, and this read latches nothing.
- R8: irq_o is active high. It is asserted exactly one clock after (pending AND enable) becomes nonzero, and it is deasserted one clock after that value becomes zero.
- R9: Any offset other than 0x16, 0x18, 0x1A and 0x1C reads as 0x0000, and writes to it change neither the mask nor the status.
- R10: With all lines low, writing 0xFFFF to 0x1C and then 0xFFFF to 0x16 leaves every line disabled, nothing pending, and irq_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register offset |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| wr_data_i | input | NUM_LINES | Write data |
| rd_data_o | output | NUM_LINES | Read data for addr_i, combinational |
| irq_lines_i | input | NUM_LINES | Raw asynchronous interrupt lines |
| irq_o | output | 1 | Level interrupt to the host, active high |

## Verification
A corrupt enable mask shows up on the very next read of either mask alias. It also shows up as a wrong irq_o level one clock after the next change in pending status. A dropped or stuck pending bit shows up at the status offset three edges after a line changes. A mis-ordered clear/set priority shows when a pending bit is lost while its line is still held high. The bench checks the synchronizer and output latencies on the exact cycle they should take effect, so an extra or missing register stage shows up as a mismatch one cycle early or late.

// File: rtl/irq_exp_pkg.sv
package irq_exp_pkg;
  parameter int unsigned OFF_STATUS = 'h16;
  parameter int unsigned OFF_LEVEL  = 'h18;
  parameter int unsigned OFF_EN_SET = 'h1A;
  parameter int unsigned OFF_EN_CLR = 'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_LEVEL,
    SEL_EN_SET,
    SEL_EN_CLR
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] clr_bits_i,
  output logic [WIDTH-1:0] status_o
);
  for (genvar n = 0; n < WIDTH; n++) begin : g_bit
    logic pend_q;
    // set beats clear when the line is still asserted
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         pend_q <= 1'b0;
      else if (level_i[n])                 pend_q <= 1'b1;
      else if (clr_en_i && clr_bits_i[n])  pend_q <= 1'b0;
    end
    assign status_o[n] = pend_q;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] bits_i,
  output logic [WIDTH-1:0] mask_o
);
  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (set_en_i) mask_q <= mask_q | bits_i;
    else if (clr_en_i) mask_q <= mask_q & ~bits_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_expander.sv
module irq_expander #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [NUM_LINES-1:0] wr_data_i,
  output logic [NUM_LINES-1:0] rd_data_o,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  output logic                 irq_o
);
  import irq_exp_pkg::*;

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(OFF_LEVEL);
  localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFF_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFF_EN_CLR);

  reg_sel_e             sel;
  logic [NUM_LINES-1:0] sync_lvl, stat_q, mask_q;
  logic                 irq_q;

  always_comb begin
    unique case (addr_i)
      A_STATUS: sel = SEL_STATUS;
      A_LEVEL:  sel = SEL_LEVEL;
      A_EN_SET: sel = SEL_EN_SET;
      A_EN_CLR: sel = SEL_EN_CLR;
      default:  sel = SEL_NONE;
    endcase
  end

  irq_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_lines_i),
    .sync_o  (sync_lvl)
  );

  irq_status_bank #(.WIDTH(NUM_LINES)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (sync_lvl),
    .clr_en_i   (wr_en_i && sel == SEL_STATUS),
    .clr_bits_i (wr_data_i),
    .status_o   (stat_q)
  );

  irq_mask_reg #(.WIDTH(NUM_LINES)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (wr_en_i && sel == SEL_EN_SET),
    .clr_en_i (wr_en_i && sel == SEL_EN_CLR),
    .bits_i   (wr_data_i),
    .mask_o   (mask_q)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS:            rd_data_o = stat_q;
      SEL_LEVEL:             rd_data_o = sync_lvl;
      SEL_EN_SET, SEL_EN_CLR: rd_data_o = mask_q;
      default:               rd_data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_q & mask_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_expander_chk.sv
module irq_expander_chk #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 wr_en_i,
  input logic [NUM_LINES-1:0] wr_data_i,
  input logic                 irq_o,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] stat_q,
  input logic [NUM_LINES-1:0] sync_lvl
);
  import irq_exp_pkg::*;

  logic wr_set, wr_clr, wr_stat, wr_none;
  assign wr_set  = wr_en_i && addr_i == ADDR_W'(OFF_EN_SET);
  assign wr_clr  = wr_en_i && addr_i == ADDR_W'(OFF_EN_CLR);
  assign wr_stat = wr_en_i && addr_i == ADDR_W'(OFF_STATUS);
  assign wr_none = wr_en_i && !wr_set && !wr_clr && !wr_stat
                   && addr_i != ADDR_W'(OFF_LEVEL);

  assert_mask_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((mask_q & $past(wr_data_i)) == $past(wr_data_i)));

  assert_mask_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((mask_q & $past(wr_data_i)) == '0));

  assert_level_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_lvl != '0) |=> ((stat_q & $past(sync_lvl)) == $past(sync_lvl)));

  assert_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> ((stat_q & $past(wr_data_i) & ~$past(sync_lvl)) == '0));

  assert_irq_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & mask_q) == '0) |=> !irq_o);

  assert_irq_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & mask_q) != '0) |=> irq_o);

  assert_unmapped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_none |=> $stable(mask_q));
endmodule

bind irq_expander irq_expander_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .irq_o     (irq_o),
  .mask_q    (mask_q),
  .stat_q    (stat_q),
  .sync_lvl  (sync_lvl)
);

// File: tb/irq_expander_tb_top.sv
module irq_expander_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_STAT = 8'h16;
  localparam logic [7:0] A_CUR  = 8'h18;
  localparam logic [7:0] A_SET  = 8'h1A;
  localparam logic [7:0] A_CLR  = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] lines = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0]  a;
    logic [15:0] exp;
    bit          chk_irq;
    logic        exp_irq;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_expander dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .addr_i      (addr),
    .wr_en_i     (we),
    .wr_data_i   (wdata),
    .rd_data_o   (rdata),
    .irq_lines_i (lines),
    .irq_o       (irq)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk(logic [7:0] a, logic [15:0] e, bit ci, logic ei, string tag);
    item_t it;
    addr = a; we = 1'b0;
    it.a = a; it.exp = e; it.chk_irq = ci; it.exp_irq = ei; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compares a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s addr=%h rd_data actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
        end
        if (it.chk_irq) begin
          checks++;
          if (irq !== it.exp_irq) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", it.tag, irq, it.exp_irq);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk(A_STAT, 16'h0000, 1, 1'b0, "R1");
    chk(A_CUR,  16'h0000, 0, 1'b0, "R1");
    chk(A_SET,  16'h0000, 0, 1'b0, "R1");
    chk(A_CLR,  16'h0000, 0, 1'b0, "R1");

    // R2/R3 set alias and read-back through both aliases
    wr(A_SET, 16'h0C00);
    chk(A_SET, 16'h0C00, 0, 1'b0, "R2");
    chk(A_CLR, 16'h0C00, 0, 1'b0, "R3");

    // R7/R4/R8 latency of line 10
    lines = 16'h0400;
    chk(A_CUR,  16'h0000, 0, 1'b0, "R7");
    chk(A_CUR,  16'h0000, 0, 1'b0, "R7");
    chk(A_CUR,  16'h0400, 0, 1'b0, "R7");
    chk(A_STAT, 16'h0400, 1, 1'b0, "R4");
    chk(A_STAT, 16'h0400, 1, 1'b1, "R8");
    lines = 16'h0000;
    tick(3);
    chk(A_STAT, 16'h0400, 1, 1'b1, "R4");
    chk(A_CUR,  16'h0000, 0, 1'b0, "R7");

    // R5/R6 clear with line 11 still high
    lines = 16'h0800;
    tick(3);
    chk(A_STAT, 16'h0C00, 0, 1'b0, "R4");
    wr(A_STAT, 16'h0C00);
    chk(A_STAT, 16'h0800, 1, 1'b1, "R6");
    lines = 16'h0000;
    tick(2);
    wr(A_STAT, 16'h0000);
    chk(A_STAT, 16'h0800, 0, 1'b0, "R5");
    wr(A_STAT, 16'h0800);
    chk(A_STAT, 16'h0000, 1, 1'b1, "R8");
    chk(A_STAT, 16'h0000, 1, 1'b0, "R5");

    // R2/R3 zero bits leave mask unchanged
    wr(A_SET, 16'h00F0);
    chk(A_SET, 16'h0CF0, 0, 1'b0, "R2");
    wr(A_CLR, 16'h0400);
    chk(A_CLR, 16'h08F0, 0, 1'b0, "R3");

    // R8 masked line does not raise irq; enabling and disabling does
    lines = 16'h0001;
    tick(4);
    chk(A_STAT, 16'h0001, 1, 1'b0, "R8");
    wr(A_SET, 16'h0001);
    chk(A_SET,  16'h08F1, 1, 1'b0, "R8");
    chk(A_STAT, 16'h0001, 1, 1'b1, "R8");
    wr(A_CLR, 16'h0001);
    chk(A_SET,  16'h08F0, 1, 1'b1, "R3");
    chk(A_SET,  16'h08F0, 1, 1'b0, "R8");

    // R9 unmapped offsets
    lines = 16'h0000;
    tick(2);
    wr(8'h20, 16'hFFFF);
    wr(8'h17, 16'hFFFF);
    chk(8'h20,  16'h0000, 0, 1'b0, "R9");
    chk(8'h17,  16'h0000, 0, 1'b0, "R9");
    chk(A_SET,  16'h08F0, 0, 1'b0, "R9");
    chk(A_STAT, 16'h0001, 1, 1'b0, "R9");

    // R10 init sequence after lines 10 and 11 pend
    lines = 16'h0C00;
    tick(4);
    chk(A_STAT, 16'h0C01, 1, 1'b1, "R4");
    lines = 16'h0000;
    tick(2);
    wr(A_CLR,  16'hFFFF);
    wr(A_STAT, 16'hFFFF);
    tick(1);
    chk(A_SET,  16'h0000, 0, 1'b0, "R10");
    chk(A_STAT, 16'h0000, 1, 1'b0, "R10");

    tick(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule